// File: doc/BRIEF.md
# Configurable UART Serial Engine

A full-duplex asynchronous serial engine with one transmit path and one receive path, both steered by a single 32-bit setup word. The word sets the bit-rate divider, the character length (5 to 8 bits), one or two stop bits, optional even parity, and separate enables for each direction. The transmit path takes a byte through a valid/ready handshake and shifts it out least significant bit first, framed by a low start bit and high stop bits. The line idles high.

The receive path synchronises the incoming line and arms only on a high-to-low transition. It confirms the start bit at mid-bit and then samples each later bit at its centre. At the end of each character it presents the byte with a one-cycle valid strobe, plus parity and framing error flags. The setup fields are captured when a character begins, so changing the setup word mid-character takes effect at the next character boundary.

Top module: `uart_engine`

## Requirements
- R1: After reset, `txd` is high, `rx_valid` and both error flags are low, and `tx_ready` is high while the transmit enable (setup bit 8) is set.
- R2: One bit period is divider+1 clock cycles, where the divider is setup bits [31:16]. The transmitted start bit is low for exactly divider+1 cycles after the handshake.
- R3: The length code in setup bits [2:1] selects 5, 6, 7 or 8 data bits for codes 00, 01, 10 and 11. Data bits are sent least significant first.
- R4: Setup bit 3 clear gives one stop bit and set gives two. `tx_ready` stays low for exactly (1 + length + parity + stops) × (divider+1) cycles after a handshake.
- R5: With setup bit 0 set, one parity bit follows the data. It makes the count of ones over the active data bits plus parity even.
- R6: A received character is delivered on `rx_data` with a one-cycle `rx_valid` pulse. Bits above the active length read as zero.
- R7: `rx_parity_err` pulses with `rx_valid` when parity is enabled and the received parity bit breaks even parity.
- R8: `rx_frame_err` pulses with `rx_valid` when the first stop bit samples low. A line held low afterwards does not start a new character.
- R9: A low pulse on `rxd` shorter than half a bit period is rejected and delivers nothing.
- R10: With the TX enable clear, `tx_ready` is low and `txd` stays high. With the RX enable (setup bit 9) clear, incoming characters are not delivered.
- R11: While a character is being sent, `tx_ready` is low and further `tx_valid` requests are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 32 | Setup word: divider [31:16], RX enable 9, TX enable 8, stop select 3, length code [2:1], parity enable 0 |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_parity_err | output | 1 | Parity mismatch on the delivered byte |
| rx_frame_err | output | 1 | Low stop bit on the delivered byte |

## Verification
The bench samples every transmitted bit at its centre for 5-, 7- and 8-bit characters, with and without parity, so a wrong length decode or an MSB-first shift shows up as a bit mismatch. It counts the exact start-bit and busy durations, which exposes an off-by-one divider (a bit period of divider cycles instead of divider+1) and a stop-bit count that ignores the select bit. On the receive side it injects bad parity, a low stop bit and a short start glitch. A receiver that drops the flags, retriggers on a stuck-low line, or accepts a glitch as a start bit delivers a wrong or extra byte.

// File: rtl/uart_engine.sv
module uart_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        txd,
  input  logic        rxd,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  output logic        rx_parity_err,
  output logic        rx_frame_err
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [15:0] div, half;
  logic [7:0]  mask;
  logic [2:0]  last_idx;
  assign div      = cfg[31:16];
  assign half     = div >> 1;
  assign mask     = 8'hFF >> (3'd3 - {1'b0, cfg[2:1]});
  assign last_idx = {1'b0, cfg[2:1]} + 3'd4;

  st_t         ts;
  logic [15:0] tcnt;
  logic [2:0]  tbit, tlast;
  logic [7:0]  tsh;
  logic        tpar, tpen, tstop2;

  assign tx_ready = cfg[8] && (ts == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts <= S_IDLE; txd <= 1'b1; tcnt <= '0; tbit <= '0; tlast <= '0;
      tsh <= '0; tpar <= 1'b0; tpen <= 1'b0; tstop2 <= 1'b0;
    end else if (ts == S_IDLE) begin
      txd <= 1'b1;
      if (tx_valid && tx_ready) begin
        ts     <= S_START;
        txd    <= 1'b0;
        tcnt   <= '0;
        tsh    <= tx_data & mask;
        tpar   <= ^(tx_data & mask);
        tpen   <= cfg[0];
        tstop2 <= cfg[3];
        tlast  <= last_idx;
      end
    end else if (tcnt != div) begin
      tcnt <= tcnt + 16'd1;
    end else begin
      tcnt <= '0;
      case (ts)
        S_START: begin ts <= S_DATA; txd <= tsh[0]; tbit <= '0; end
        S_DATA: begin
          if (tbit == tlast) begin
            tbit <= '0;
            if (tpen) begin ts <= S_PAR; txd <= tpar; end
            else      begin ts <= S_STOP; txd <= 1'b1; end
          end else begin
            tbit <= tbit + 3'd1;
            tsh  <= tsh >> 1;
            txd  <= tsh[1];
          end
        end
        S_PAR: begin ts <= S_STOP; txd <= 1'b1; tbit <= '0; end
        S_STOP: begin
          if (tstop2 && tbit == 3'd0) tbit <= 3'd1;
          else ts <= S_IDLE;
        end
        default: ts <= S_IDLE;
      endcase
    end
  end

  logic        rs1, rs2, rs3;
  st_t         rst_q;
  logic [15:0] rcnt;
  logic [2:0]  rbit, rlast;
  logic [7:0]  rsh;
  logic        rpen, racc, rperr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; rs3 <= 1'b1;
    end else begin
      rs1 <= rxd; rs2 <= rs1; rs3 <= rs2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= S_IDLE; rcnt <= '0; rbit <= '0; rlast <= '0; rsh <= '0;
      rpen <= 1'b0; racc <= 1'b0; rperr <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; rx_parity_err <= 1'b0; rx_frame_err <= 1'b0;
    end else begin
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      case (rst_q)
        S_IDLE:
          if (cfg[9] && rs3 && !rs2) begin
            rst_q <= S_START; rcnt <= '0; rlast <= last_idx; rpen <= cfg[0];
          end
        S_START:
          if (rcnt == half) begin
            rcnt <= '0;
            if (!rs2) begin
              rst_q <= S_DATA; rbit <= '0; rsh <= '0; racc <= 1'b0; rperr <= 1'b0;
            end else rst_q <= S_IDLE;
          end else rcnt <= rcnt + 16'd1;
        default:
          if (rcnt != div) rcnt <= rcnt + 16'd1;
          else begin
            rcnt <= '0;
            case (rst_q)
              S_DATA: begin
                rsh[rbit] <= rs2;
                racc      <= racc ^ rs2;
                if (rbit == rlast) rst_q <= rpen ? S_PAR : S_STOP;
                else rbit <= rbit + 3'd1;
              end
              S_PAR: begin rperr <= racc ^ rs2; rst_q <= S_STOP; end
              default: begin
                rx_valid      <= 1'b1;
                rx_data       <= rsh;
                rx_frame_err  <= !rs2;
                rx_parity_err <= rpen && rperr;
                rst_q         <= S_IDLE;
              end
            endcase
          end
      endcase
    end
  end
endmodule

module uart_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg,
  input logic        tx_ready,
  input logic        txd,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        rx_parity_err,
  input logic        rx_frame_err,
  input logic [2:0]  rx_len
);
  a_r10_tx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[8] |-> !tx_ready);
  a_r11_ready_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (({24'd0, rx_data} >> (32'(rx_len) + 32'd1)) == 32'd0));
  a_r7_parity_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_parity_err |-> rx_valid);
  a_r8_frame_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> rx_valid);
endmodule

bind uart_engine uart_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
  .rx_frame_err(rx_frame_err), .rx_len(rlast)
);

// File: tb/sim_uart_engine.sv
module sim_uart_engine;
  localparam int DIV = 15;
  localparam int P   = DIV + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg;
  logic [7:0]  tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, txd, rxd = 1'b1;
  logic rx_valid, rx_parity_err, rx_frame_err;
  int checks = 0, errors = 0, got_cnt = 0;
  logic [7:0] got_data;
  logic got_pe, got_fe;

  always #10 clk = ~clk;

  uart_engine u0 (.clk(clk), .rst_n(rst_n), .cfg(cfg), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err));

  always @(negedge clk) if (rx_valid) begin
    got_cnt++; got_data = rx_data; got_pe = rx_parity_err; got_fe = rx_frame_err;
  end

  function automatic logic [31:0] mk(bit rxe, bit txe, bit st2, logic [1:0] lc, bit pe);
    return {16'(DIV), 6'd0, rxe, txe, 4'd0, st2, lc, pe};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic accept(logic [7:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1'b1;
    @(posedge clk); #1 tx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
    chk(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk(rx_valid === 1'b0 && rx_parity_err === 1'b0 && rx_frame_err === 1'b0,
        "R1 rx outputs", int'(rx_valid), 0);
  endtask

  task automatic t_tx_frame(logic [1:0] lc, bit pe, bit st2, logic [7:0] d, string tag);
    logic [11:0] exp;
    int n, len;
    logic [7:0] m;
    len = 5 + int'(lc);
    m = 8'hFF >> (3 - int'(lc));
    exp = '0; n = 0;
    exp[n++] = 1'b0;
    for (int i = 0; i < len; i++) exp[n++] = d[i];
    if (pe) exp[n++] = ^(d & m);
    exp[n++] = 1'b1;
    if (st2) exp[n++] = 1'b1;
    cfg = mk(1, 1, st2, lc, pe);
    accept(d);
    repeat (P/2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(txd === exp[i], tag, int'(txd), int'(exp[i]));
      repeat (P) @(negedge clk);
    end
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic t_tx_timing(logic [1:0] lc, bit pe, bit st2, int expbusy);
    int lowc = 0, busy = 0;
    bit ign = 1'b0;
    cfg = mk(1, 1, st2, lc, pe);
    accept(8'hFF);
    @(negedge clk);
    tx_valid = 1'b1;
    while (!tx_ready) begin
      busy++;
      if (txd === 1'b0) lowc++;
      @(posedge clk); if (!tx_ready && txd === 1'b0 && busy > P) ign = 1'b1;
      @(negedge clk);
      if (busy > 1000) break;
    end
    tx_valid = 1'b0;
    chk(lowc == P, "R2 start bit length", lowc, P);
    chk(busy == expbusy, "R4 busy length", busy, expbusy);
    chk(!ign, "R11 no accept while busy", int'(ign), 0);
    @(negedge clk);
    if (!tx_ready) while (!tx_ready) @(negedge clk);
  endtask

  task automatic send_rx(logic [1:0] lc, bit pe, logic [7:0] d, bit bad_par, bit bad_stop);
    int len;
    logic [7:0] m;
    len = 5 + int'(lc);
    m = 8'hFF >> (3 - int'(lc));
    @(negedge clk); rxd = 1'b0; repeat (P) @(negedge clk);
    for (int i = 0; i < len; i++) begin rxd = d[i]; repeat (P) @(negedge clk); end
    if (pe) begin rxd = (^(d & m)) ^ bad_par; repeat (P) @(negedge clk); end
    rxd = !bad_stop; repeat (P) @(negedge clk);
    rxd = 1'b1; repeat (2*P) @(negedge clk);
  endtask

  task automatic t_rx(logic [1:0] lc, bit pe, logic [7:0] d, bit bp, bit bs, string tag);
    int c0;
    logic [7:0] m;
    m = 8'hFF >> (3 - int'(lc));
    cfg = mk(1, 1, 0, lc, pe);
    c0 = got_cnt;
    send_rx(lc, pe, d, bp, bs);
    chk(got_cnt == c0 + 1, {tag, " R6 one delivery"}, got_cnt - c0, 1);
    chk(got_data === (d & m), {tag, " R6 data"}, int'(got_data), int'(d & m));
    chk(got_pe === bp, {tag, " R7 parity flag"}, int'(got_pe), int'(bp));
    chk(got_fe === bs, {tag, " R8 frame flag"}, int'(got_fe), int'(bs));
  endtask

  task automatic t_glitch;
    int c0 = got_cnt;
    cfg = mk(1, 1, 0, 2'b11, 0);
    @(negedge clk); rxd = 1'b0; repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (12*P) @(negedge clk);
    chk(got_cnt == c0, "R9 glitch rejected", got_cnt - c0, 0);
  endtask

  task automatic t_disable;
    int c0;
    cfg = mk(1, 0, 0, 2'b11, 0);
    @(negedge clk);
    chk(tx_ready === 1'b0, "R10 tx_ready when disabled", int'(tx_ready), 0);
    tx_valid = 1'b1; tx_data = 8'h00;
    repeat (3*P) @(negedge clk);
    chk(txd === 1'b1, "R10 txd held high", int'(txd), 1);
    tx_valid = 1'b0;
    cfg = mk(0, 1, 0, 2'b11, 0);
    c0 = got_cnt;
    send_rx(2'b11, 0, 8'h3C, 0, 0);
    chk(got_cnt == c0, "R10 rx disabled", got_cnt - c0, 0);
    cfg = mk(1, 1, 0, 2'b11, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg = {16'(DIV), 16'h0306};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_frame(2'b11, 0, 0, 8'hA5, "R3 8N1 bit");
    t_tx_frame(2'b00, 1, 0, 8'hF7, "R5 5-bit parity bit");
    t_tx_frame(2'b10, 1, 1, 8'h2B, "R4 7E2 bit");
    t_tx_timing(2'b11, 0, 0, 10*P);
    t_tx_timing(2'b10, 1, 1, 11*P);
    t_rx(2'b11, 0, 8'h96, 0, 0, "8N1");
    t_rx(2'b01, 1, 8'hED, 0, 0, "6E1");
    t_rx(2'b11, 1, 8'h5A, 1, 0, "R7 bad parity");
    t_rx(2'b11, 0, 8'h81, 0, 1, "R8 low stop");
    t_glitch();
    t_disable();
    t_rx(2'b11, 0, 8'h42, 0, 0, "R10 re-enabled");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule